// File: doc/BRIEF.md
# Floppy Controller Glue Register with NMI Generation

This block is a small control register written by an 8-bit processor and placed between that processor and a floppy disk controller. Its bits drive the controller's active-low reset, the drive-select lines, the side-select line and the density line. The processor can read back the last value written.

The block also merges the controller's interrupt-request and data-request outputs into one non-maskable interrupt for the processor. The merged request is ANDed with an enable. The processor sees a one-clock pulse only when that gated condition goes from low to high. A request that stays high, or one that falls, produces no further pulse.

The parameter `GATED` chooses between two register layouts. With `GATED = 1`, a register bit gates the interrupt. With `GATED = 0`, the interrupt is always enabled and the freed bits carry a third drive select plus side and density.

Top module: `fdc_nmi_glue`

## Requirements
- R1: After reset the register reads back 0x20 when `GATED=1` and 0x04 when `GATED=0`. In both layouts `fdc_rst_n` is 1 and `nmi_pulse` is 0.
- R2: A write with `wr_en` high loads `wr_data[5:0]` on that clock edge. `rd_data` shows the stored value from the next cycle on, and bits 7 and 6 always read 0.
- R3: With `GATED=1` the fields decode as follows. Bit 5 is the controller reset, active low, so 0 means reset. Bit 4 is the NMI enable, active low, so 0 means enabled. Bit 3 drives `single_den`, bit 2 drives `side_sel` and bits 1..0 drive `drv_sel[1:0]`. `drv_sel[2]` is always 0.
- R4: With `GATED=0` the fields decode as follows. Bit 5 drives `single_den`, where 1 means single density and 0 means double. Bit 4 drives `side_sel`, where 1 means side 1. Bit 3 drives `drv_sel[2]`, bit 1 drives `drv_sel[1]` and bit 0 drives `drv_sel[0]`. Bit 2 is the controller reset, active low.
- R5: The NMI condition is (`fdc_intr` OR `fdc_dreq`) AND enable. Either request alone is enough to raise it.
- R6: `nmi_pulse` is high for exactly one cycle. It goes high in the cycle after a clock edge at which the condition is sampled high, provided the condition was sampled low at the edge before. A held or falling condition gives no pulse.
- R7: With `GATED=1` and bit 4 set to 1, requests produce no pulse. If a request is already high when bit 4 is then cleared, a pulse follows, because the gated condition rises. With `GATED=0`, every rising request produces a pulse whatever the register holds.
- R8: The edge detector's stored previous condition is 1 at reset. A request held high through reset therefore gives no pulse until it falls and rises again.
- R9: `fdc_rst_n` and the drive, side and density outputs follow the stored register bits directly. They change in the same cycle that `rd_data` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 8 | Data to write into the register |
| rd_data | output | 8 | Register read-back value |
| fdc_intr | input | 1 | Controller interrupt request, active high, synchronous |
| fdc_dreq | input | 1 | Controller data request, active high, synchronous |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt pulse to the CPU |
| fdc_rst_n | output | 1 | Controller reset, active low |
| drv_sel | output | 3 | Drive select lines |
| side_sel | output | 1 | Side select, 1 = side 1 |
| single_den | output | 1 | Density select, 1 = single density |

## Verification
The assertions assume that `fdc_intr` and `fdc_dreq` are synchronous to `clk` and hold steady across each edge. They also assume that `wr_en` is a plain level sampled at the edge, with no relation required to the requests. The bench changes every input only on the falling clock edge, so each value is settled when the rising edge samples it. The bench also keeps both requests low during the register sweep, so the write checks and the pulse checks never overlap.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;

    localparam int CPU_DATA_W = 8;
    localparam int USED_W     = 6;
    localparam int DRV_W      = 3;

    typedef struct packed {
        logic [DRV_W-1:0] drv;
        logic             side;
        logic             single_den;
        logic             ctl_rst_n;
        logic             irq_en;
    } fdc_ctl_t;

endpackage

// File: rtl/fdc_ctl_reg.sv
module fdc_ctl_reg
    import fdc_glue_pkg::*;
#(
    parameter int DATA_W = CPU_DATA_W,
    parameter int KEEP_W = USED_W,
    parameter bit GATED  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output fdc_ctl_t          ctl
);

    localparam int                RST_BIT   = GATED ? 5 : 2;
    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << KEEP_W) - 1);
    localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'(1 << RST_BIT);

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.val = wr_data & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.val;

    generate
        if (GATED) begin : g_gated
            assign ctl.ctl_rst_n  = st_q.val[5];
            assign ctl.irq_en     = ~st_q.val[4];
            assign ctl.single_den = st_q.val[3];
            assign ctl.side       = st_q.val[2];
            assign ctl.drv        = {1'b0, st_q.val[1:0]};
        end else begin : g_open
            assign ctl.single_den = st_q.val[5];
            assign ctl.side       = st_q.val[4];
            assign ctl.drv        = {st_q.val[3], st_q.val[1:0]};
            assign ctl.ctl_rst_n  = st_q.val[2];
            assign ctl.irq_en     = 1'b1;
        end
    endgenerate

    // R2: a write becomes visible on the read-back in the next cycle
    a_r2_write_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == ($past(wr_data) & KEEP_MASK));

    // R2: without a write the register holds its value
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    // R2: the top bits always read 0
    a_r2_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:KEEP_W] == '0);

endmodule

// File: rtl/fdc_nmi_edge.sv
module fdc_nmi_edge #(
    parameter int N_REQ = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    input  logic             enable,
    output logic             nmi
);

    typedef struct packed {
        logic prev;
        logic pulse;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        cond;

    assign cond = (|req) & enable;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = cond & ~st_q.prev;
        st_d.prev  = cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev  <= 1'b1;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi = st_q.pulse;

    // R6: a pulse lasts exactly one cycle
    a_r6_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !nmi);

    // R6: a pulse requires the condition low two edges back
    a_r6_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> ($past(cond) && !$past(cond, 2)));

endmodule

// File: rtl/fdc_nmi_glue.sv
module fdc_nmi_glue
    import fdc_glue_pkg::*;
#(
    parameter bit GATED = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CPU_DATA_W-1:0] wr_data,
    output logic [CPU_DATA_W-1:0] rd_data,
    input  logic                  fdc_intr,
    input  logic                  fdc_dreq,
    output logic                  nmi_pulse,
    output logic                  fdc_rst_n,
    output logic [DRV_W-1:0]      drv_sel,
    output logic                  side_sel,
    output logic                  single_den
);

    fdc_ctl_t ctl;

    fdc_ctl_reg #(
        .DATA_W (CPU_DATA_W),
        .KEEP_W (USED_W),
        .GATED  (GATED)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ctl     (ctl)
    );

    fdc_nmi_edge #(
        .N_REQ (2)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    ({fdc_dreq, fdc_intr}),
        .enable (ctl.irq_en),
        .nmi    (nmi_pulse)
    );

    assign fdc_rst_n  = ctl.ctl_rst_n;
    assign drv_sel    = ctl.drv;
    assign side_sel   = ctl.side;
    assign single_den = ctl.single_den;

    // R5: a pulse needs at least one request sampled high at the edge before
    a_r5_req_seen: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> $past(fdc_intr || fdc_dreq));

    generate
        if (GATED) begin : g_chk_gated
            // R7: no pulse when the enable bit was set at the sampling edge
            a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
                nmi_pulse |-> !$past(rd_data[4]));
            // R9: the reset line tracks register bit 5
            a_r9_rst_track: assert property (@(posedge clk) disable iff (!rst_n)
                fdc_rst_n == rd_data[5]);
        end else begin : g_chk_open
            // R9: the reset line tracks register bit 2
            a_r9_rst_track: assert property (@(posedge clk) disable iff (!rst_n)
                fdc_rst_n == rd_data[2]);
        end
    endgenerate

endmodule

// File: tb/test_fdc_nmi_glue.sv
module test_fdc_nmi_glue;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fdc_intr = 1'b0;
    logic       fdc_dreq = 1'b0;

    logic [7:0] rd_g, rd_a;
    logic       nmi_g, nmi_a, rst_g, rst_a, side_g, side_a, den_g, den_a;
    logic [2:0] drv_g, drv_a;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fdc_nmi_glue #(.GATED(1'b1)) i_fdc_nmi_glue (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_g), .fdc_intr(fdc_intr), .fdc_dreq(fdc_dreq),
        .nmi_pulse(nmi_g), .fdc_rst_n(rst_g), .drv_sel(drv_g),
        .side_sel(side_g), .single_den(den_g)
    );

    fdc_nmi_glue #(.GATED(1'b0)) i_fdc_nmi_glue_alt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_a), .fdc_intr(fdc_intr), .fdc_dreq(fdc_dreq),
        .nmi_pulse(nmi_a), .fdc_rst_n(rst_a), .drv_sel(drv_a),
        .side_sel(side_a), .single_den(den_a)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_data = v;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // set requests, expect pulse in the next cycle, then none
    task automatic req_step(input logic i, input logic d, input logic eg, input logic ea, input string req);
        @(negedge clk);
        fdc_intr = i;
        fdc_dreq = d;
        @(negedge clk);
        chk({req, " gated nmi"}, 32'(nmi_g), 32'(eg));
        chk({req, " open nmi"}, 32'(nmi_a), 32'(ea));
        @(negedge clk);
        chk({req, " gated nmi after"}, 32'(nmi_g), 32'h0);
        chk({req, " open nmi after"}, 32'(nmi_a), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R8: request high through reset
        fdc_intr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 gated readback", 32'(rd_g), 32'h20);
        chk("R1 open readback", 32'(rd_a), 32'h04);
        chk("R1 gated rst_n", 32'(rst_g), 32'h1);
        chk("R1 open rst_n", 32'(rst_a), 32'h1);
        chk("R1 gated nmi", 32'(nmi_g), 32'h0);
        chk("R1 open nmi", 32'(nmi_a), 32'h0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8 gated held req", 32'(nmi_g), 32'h0);
            chk("R8 open held req", 32'(nmi_a), 32'h0);
        end
        req_step(1'b0, 1'b0, 1'b0, 1'b0, "R8 fall");
        req_step(1'b1, 1'b0, 1'b1, 1'b1, "R8 re-rise");
        req_step(1'b0, 1'b0, 1'b0, 1'b0, "R6 fall");

        // R2 R3 R4 R9: sweep every value
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            wr(b);
            chk("R2 gated readback", 32'(rd_g), 32'(b & 8'h3F));
            chk("R2 open readback", 32'(rd_a), 32'(b & 8'h3F));
            chk("R9 R3 gated rst_n", 32'(rst_g), 32'(b[5]));
            chk("R3 gated den", 32'(den_g), 32'(b[3]));
            chk("R3 gated side", 32'(side_g), 32'(b[2]));
            chk("R3 gated drv", 32'(drv_g), 32'({1'b0, b[1:0]}));
            chk("R4 open den", 32'(den_a), 32'(b[5]));
            chk("R4 open side", 32'(side_a), 32'(b[4]));
            chk("R4 open drv", 32'(drv_a), 32'({b[3], b[1:0]}));
            chk("R9 R4 open rst_n", 32'(rst_a), 32'(b[2]));
            chk("R6 no nmi in sweep", 32'({nmi_g, nmi_a}), 32'h0);
        end

        // R5 R6 with gating enabled
        wr(8'h20);
        req_step(1'b1, 1'b0, 1'b1, 1'b1, "R5 intr alone");
        req_step(1'b1, 1'b0, 1'b0, 1'b0, "R6 held");
        req_step(1'b0, 1'b0, 1'b0, 1'b0, "R6 fall");
        req_step(1'b0, 1'b1, 1'b1, 1'b1, "R5 dreq alone");
        req_step(1'b1, 1'b1, 1'b0, 1'b0, "R6 add intr while high");
        req_step(1'b1, 1'b0, 1'b0, 1'b0, "R6 drop dreq keep intr");
        req_step(1'b0, 1'b0, 1'b0, 1'b0, "R6 both low");
        req_step(1'b1, 1'b1, 1'b1, 1'b1, "R5 both rise");
        req_step(1'b0, 1'b0, 1'b0, 1'b0, "R6 both fall");

        // R7 gating
        wr(8'h30);
        req_step(1'b1, 1'b0, 1'b0, 1'b1, "R7 blocked intr");
        req_step(1'b0, 1'b0, 1'b0, 1'b0, "R7 drop");
        req_step(1'b0, 1'b1, 1'b0, 1'b1, "R7 blocked dreq");
        // enable while request still high: pulse two cycles after the write strobe
        @(negedge clk);
        wr_data = 8'h20;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        chk("R7 enable no pulse yet", 32'(nmi_g), 32'h0);
        @(negedge clk);
        chk("R7 enable with req high", 32'(nmi_g), 32'h1);
        chk("R7 open unaffected", 32'(nmi_a), 32'h0);
        @(negedge clk);
        chk("R6 enable pulse ends", 32'(nmi_g), 32'h0);
        req_step(1'b0, 1'b0, 1'b0, 1'b0, "R7 final drop");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule